// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core

This block is a small 8-bit processor core with one accumulator, AX, and two helper registers, BX and CX. Each clock it reads one opcode from a program ROM port, decodes it and retires it in the same clock. The operations are register moves, add, subtract, increment, decrement, OR and NOT on the accumulator, pushes and pops on a stack kept in data RAM, a read of an 8-bit input port, and a write to an 8-bit output port that carries a one-clock strobe. Two opcodes take one operand byte after them. One is a load of AX from a RAM address. The other is a jump taken when the overflow flag is clear. Each of these two spends one extra clock reading its operand.

The ROM and the RAM are read combinationally. The address leaves the core and the data must return within the same clock. RAM writes happen at the clock edge while the write enable is high. The opcode map is fixed and irregular. Any byte outside that map is a no-operation.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and right after it, AX, BX, CX, the overflow flag, the program counter and the stack pointer are all zero. This shows as rom_addr = 0, out_data = 0, out_stb = 0 and ram_we = 0.
- R2: An opcode outside the two-byte pair advances rom_addr by one per clock. Opcodes 0x04 and 0x4A take two clocks and advance rom_addr by two, unless a jump is taken.
- R3: 0x00 clears AX. 0x01 copies BX to AX, 0x02 copies CX to AX, 0x05 copies AX to BX and 0x06 copies AX to CX.
- R4: Arithmetic wraps modulo 256. 0x0D adds BX to AX and 0x0E adds CX. 0x11 subtracts BX from AX and 0x12 subtracts CX. 0x0C increments AX and 0x10 decrements it.
- R5: The overflow flag holds the two's-complement signed overflow of the most recent 0x0D, 0x0E, 0x11, 0x12, 0x0C or 0x10. No other opcode changes it.
- R6: 0x19 ORs BX into AX, 0x1E ORs CX into AX, and 0x14 inverts every bit of AX.
- R7: 0x31 loads in_data into AX. 0x32 puts AX on out_data and raises out_stb for exactly the following clock.
- R8: Opcodes 0x80, 0x81 and 0x82 push AX, BX and CX. In the same clock the stack pointer drops by one, and ram_we is high with ram_addr set to the new pointer and ram_wdata set to the register. ram_we is never high at any other time.
- R9: Opcodes 0x90, 0x91 and 0x92 load AX, BX and CX from RAM at the stack pointer, then increment the pointer. A stack pointer of 0 wraps, so the first push goes to 0xFF.
- R10: 0x04 followed by byte n loads AX from RAM address n in the operand clock.
- R11: 0x4A followed by byte t moves the program counter to t when the overflow flag is clear, and past the operand when it is set.
- R12: Every other opcode changes no register and no flag. It only advances the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_addr | output | ADDR_W | Program counter, used as the ROM read address |
| rom_data | input | DATA_W | ROM word at rom_addr, same clock |
| ram_addr | output | ADDR_W | Data RAM address: stack slot or load address |
| ram_wdata | output | DATA_W | Data written on a push |
| ram_we | output | 1 | RAM write enable, active for pushes |
| ram_rdata | input | DATA_W | RAM word at ram_addr, same clock |
| in_data | input | DATA_W | Input port value |
| out_data | output | DATA_W | Output port register |
| out_stb | output | 1 | One-clock pulse when out_data is refreshed |

## Verification
Most of the core's state is hidden, so a corrupted register or flag shows up late at the ports. A bad AX or helper register is seen only at the next output write or push. A wrong overflow flag is seen only when a later jump goes down the wrong path, and it shows on rom_addr two clocks after the jump opcode is fetched. A wrong stack pointer shows on the very next push address. The bench therefore compares rom_addr, the write port and the output port against an independent instruction-level model on every clock. It also runs a program that routes each register, and the flag through both jump outcomes, out to these ports soon after each change.

// File: rtl/acc_pkg.sv
package acc_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_CLR    = 8'h00;
   localparam logic [OPC_W-1:0] OPC_A_B    = 8'h01;
   localparam logic [OPC_W-1:0] OPC_A_C    = 8'h02;
   localparam logic [OPC_W-1:0] OPC_LOAD   = 8'h04;
   localparam logic [OPC_W-1:0] OPC_B_A    = 8'h05;
   localparam logic [OPC_W-1:0] OPC_C_A    = 8'h06;
   localparam logic [OPC_W-1:0] OPC_INC    = 8'h0C;
   localparam logic [OPC_W-1:0] OPC_ADD_B  = 8'h0D;
   localparam logic [OPC_W-1:0] OPC_ADD_C  = 8'h0E;
   localparam logic [OPC_W-1:0] OPC_DEC    = 8'h10;
   localparam logic [OPC_W-1:0] OPC_SUB_B  = 8'h11;
   localparam logic [OPC_W-1:0] OPC_SUB_C  = 8'h12;
   localparam logic [OPC_W-1:0] OPC_NOT    = 8'h14;
   localparam logic [OPC_W-1:0] OPC_OR_B   = 8'h19;
   localparam logic [OPC_W-1:0] OPC_OR_C   = 8'h1E;
   localparam logic [OPC_W-1:0] OPC_IN     = 8'h31;
   localparam logic [OPC_W-1:0] OPC_OUT    = 8'h32;
   localparam logic [OPC_W-1:0] OPC_JNO    = 8'h4A;
   localparam logic [OPC_W-1:0] OPC_PUSH_A = 8'h80;
   localparam logic [OPC_W-1:0] OPC_PUSH_B = 8'h81;
   localparam logic [OPC_W-1:0] OPC_PUSH_C = 8'h82;
   localparam logic [OPC_W-1:0] OPC_POP_A  = 8'h90;
   localparam logic [OPC_W-1:0] OPC_POP_B  = 8'h91;
   localparam logic [OPC_W-1:0] OPC_POP_C  = 8'h92;

   typedef enum logic [3:0] {
      K_NOP, K_CLR, K_IN, K_OUT, K_TO_ACC, K_FROM_ACC,
      K_LOAD, K_ALU, K_JNO, K_PUSH, K_POP
   } kind_e;

   typedef enum logic [2:0] {
      F_ADD, F_SUB, F_INC, F_DEC, F_OR, F_NOT
   } alu_fn_e;

   typedef enum logic [1:0] {
      SEL_AX, SEL_BX, SEL_CX
   } reg_sel_e;

   typedef struct packed {
      kind_e    kind;
      alu_fn_e  fn;
      reg_sel_e sel;
   } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output dec_t             dec
);

   always_comb begin
      dec      = '{kind: K_NOP, fn: F_ADD, sel: SEL_AX};
      case (opcode)
         OPC_CLR:    dec.kind = K_CLR;
         OPC_IN:     dec.kind = K_IN;
         OPC_OUT:    dec.kind = K_OUT;
         OPC_A_B:    begin dec.kind = K_TO_ACC;   dec.sel = SEL_BX; end
         OPC_A_C:    begin dec.kind = K_TO_ACC;   dec.sel = SEL_CX; end
         OPC_B_A:    begin dec.kind = K_FROM_ACC; dec.sel = SEL_BX; end
         OPC_C_A:    begin dec.kind = K_FROM_ACC; dec.sel = SEL_CX; end
         OPC_LOAD:   dec.kind = K_LOAD;
         OPC_JNO:    dec.kind = K_JNO;
         OPC_ADD_B:  begin dec.kind = K_ALU; dec.fn = F_ADD; dec.sel = SEL_BX; end
         OPC_ADD_C:  begin dec.kind = K_ALU; dec.fn = F_ADD; dec.sel = SEL_CX; end
         OPC_SUB_B:  begin dec.kind = K_ALU; dec.fn = F_SUB; dec.sel = SEL_BX; end
         OPC_SUB_C:  begin dec.kind = K_ALU; dec.fn = F_SUB; dec.sel = SEL_CX; end
         OPC_INC:    begin dec.kind = K_ALU; dec.fn = F_INC; end
         OPC_DEC:    begin dec.kind = K_ALU; dec.fn = F_DEC; end
         OPC_OR_B:   begin dec.kind = K_ALU; dec.fn = F_OR;  dec.sel = SEL_BX; end
         OPC_OR_C:   begin dec.kind = K_ALU; dec.fn = F_OR;  dec.sel = SEL_CX; end
         OPC_NOT:    begin dec.kind = K_ALU; dec.fn = F_NOT; end
         OPC_PUSH_A: begin dec.kind = K_PUSH; dec.sel = SEL_AX; end
         OPC_PUSH_B: begin dec.kind = K_PUSH; dec.sel = SEL_BX; end
         OPC_PUSH_C: begin dec.kind = K_PUSH; dec.sel = SEL_CX; end
         OPC_POP_A:  begin dec.kind = K_POP;  dec.sel = SEL_AX; end
         OPC_POP_B:  begin dec.kind = K_POP;  dec.sel = SEL_BX; end
         OPC_POP_C:  begin dec.kind = K_POP;  dec.sel = SEL_CX; end
         default:    dec.kind = K_NOP;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_fn_e      fn,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         ovf,
   output logic         ovf_upd
);

   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      y       = a;
      ovf     = 1'b0;
      ovf_upd = 1'b0;
      case (fn)
         F_ADD: begin
            y       = a + b;
            ovf     = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            ovf_upd = 1'b1;
         end
         F_SUB: begin
            y       = a - b;
            ovf     = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            ovf_upd = 1'b1;
         end
         F_INC: begin
            y       = a + ONE;
            ovf     = (a == MAX_POS);
            ovf_upd = 1'b1;
         end
         F_DEC: begin
            y       = a - ONE;
            ovf     = (a == MIN_NEG);
            ovf_upd = 1'b1;
         end
         F_OR:    y = a | b;
         F_NOT:   y = ~a;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_data,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              ram_we,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] out_data,
   output logic              out_stb
);

   localparam int NUM_AUX = 2;

   // elaboration-time parameter checks
   if (DATA_W < OPC_W) begin : g_bad_data_w
      $error("acc_core: DATA_W must hold a full opcode");
   end
   if (ADDR_W > DATA_W || ADDR_W < 2) begin : g_bad_addr_w
      $error("acc_core: ADDR_W must lie between 2 and DATA_W");
   end

   logic [DATA_W-1:0] ax_q;
   logic              ovf_q;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] sp_q;
   logic              opnd_q;   // operand cycle of a two-byte opcode
   logic              jno_q;    // pending two-byte op is the jump
   logic [DATA_W-1:0] out_q;
   logic              stb_q;

   logic [DATA_W-1:0] aux_v [NUM_AUX];
   dec_t              dec;
   logic              exec;
   logic [ADDR_W-1:0] operand;
   logic [ADDR_W-1:0] sp_dn;
   logic [DATA_W-1:0] src_val;
   logic [DATA_W-1:0] alu_y;
   logic              alu_ovf;
   logic              alu_upd;

   acc_decode u_dec (
      .opcode (rom_data[OPC_W-1:0]),
      .dec    (dec)
   );

   assign exec    = !opnd_q;
   assign operand = rom_data[ADDR_W-1:0];
   assign sp_dn   = sp_q - 1'b1;

   always_comb begin
      case (dec.sel)
         SEL_BX:  src_val = aux_v[0];
         SEL_CX:  src_val = aux_v[1];
         default: src_val = ax_q;
      endcase
   end

   acc_alu #(.W(DATA_W)) u_alu (
      .fn      (dec.fn),
      .a       (ax_q),
      .b       (src_val),
      .y       (alu_y),
      .ovf     (alu_ovf),
      .ovf_upd (alu_upd)
   );

   // helper registers, one slot per generate instance
   for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
      logic [DATA_W-1:0] r_q;
      logic              hit;
      assign hit = exec && (dec.sel == reg_sel_e'(i + 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= '0;
         end else if (hit && dec.kind == K_FROM_ACC) begin
            r_q <= ax_q;
         end else if (hit && dec.kind == K_POP) begin
            r_q <= ram_rdata;
         end
      end
      assign aux_v[i] = r_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ax_q   <= '0;
         ovf_q  <= 1'b0;
         pc_q   <= '0;
         sp_q   <= '0;
         opnd_q <= 1'b0;
         jno_q  <= 1'b0;
         out_q  <= '0;
         stb_q  <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (opnd_q) begin
            opnd_q <= 1'b0;
            if (jno_q) begin
               pc_q <= ovf_q ? pc_q + 1'b1 : operand;
            end else begin
               ax_q <= ram_rdata;
               pc_q <= pc_q + 1'b1;
            end
         end else begin
            pc_q <= pc_q + 1'b1;
            case (dec.kind)
               K_CLR:    ax_q <= '0;
               K_IN:     ax_q <= in_data;
               K_OUT: begin
                  out_q <= ax_q;
                  stb_q <= 1'b1;
               end
               K_TO_ACC: ax_q <= src_val;
               K_LOAD, K_JNO: begin
                  opnd_q <= 1'b1;
                  jno_q  <= (dec.kind == K_JNO);
               end
               K_ALU: begin
                  ax_q <= alu_y;
                  if (alu_upd) ovf_q <= alu_ovf;
               end
               K_PUSH:   sp_q <= sp_dn;
               K_POP: begin
                  sp_q <= sp_q + 1'b1;
                  if (dec.sel == SEL_AX) ax_q <= ram_rdata;
               end
               default: ;
            endcase
         end
      end
   end

   assign rom_addr  = pc_q;
   assign ram_we    = exec && (dec.kind == K_PUSH);
   assign ram_addr  = opnd_q ? operand : ((dec.kind == K_PUSH) ? sp_dn : sp_q);
   assign ram_wdata = src_val;
   assign out_data  = out_q;
   assign out_stb   = stb_q;

   // ---------------- assertions ----------------
   AST_OPERAND_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_q |=> !opnd_q);  // R2

   AST_NOP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && dec.kind == K_NOP) |=>
         (rom_addr == ADDR_W'($past(rom_addr) + 1'b1)) && $stable(ax_q) && $stable(ovf_q));  // R12

   AST_LOGIC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && dec.kind != K_ALU) |=> $stable(ovf_q));  // R5

   AST_OUT_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && dec.kind == K_OUT) |=> (out_stb && out_data == $past(ax_q)));  // R7

   AST_PUSH_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> (sp_q == $past(ram_addr)));  // R8

   AST_POP_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && dec.kind == K_POP) |=> (sp_q == ADDR_W'($past(sp_q) + 1'b1)));  // R9

   AST_JNO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_q && jno_q && !ovf_q) |=> (rom_addr == $past(rom_data[ADDR_W-1:0])));  // R11

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rom_addr, rom_data, ram_addr, ram_wdata, ram_rdata, in_data, out_data;
   logic       ram_we, out_stb;

   logic [7:0] rom  [256];
   logic [7:0] ram  [256];
   logic [7:0] mram [256];

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  vis [256];
   logic [7:0] outs [$];
   logic [15:0] pushes [$];

   always #4 clk = ~clk;   // 125 MHz

   assign rom_data  = rom[rom_addr];
   assign ram_rdata = ram[ram_addr];
   always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

   acc_core u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rom_addr  (rom_addr),
      .rom_data  (rom_data),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .ram_we    (ram_we),
      .ram_rdata (ram_rdata),
      .in_data   (in_data),
      .out_data  (out_data),
      .out_stb   (out_stb)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_ax = 0, m_bx = 0, m_cx = 0, m_pc = 0, m_sp = 0, m_out = 0, m_pend = 0, m_op;
   bit         m_ovf = 0, m_stb = 0, m_ph = 0;
   string      m_tag = "R1";

   function automatic string tag_of(input logic [7:0] op);
      case (op)
         8'h00, 8'h01, 8'h02, 8'h05, 8'h06:         return "R3";
         8'h0C, 8'h0D, 8'h0E, 8'h10, 8'h11, 8'h12: return "R4";
         8'h14, 8'h19, 8'h1E:                       return "R6";
         8'h31, 8'h32:                              return "R7";
         8'h80, 8'h81, 8'h82:                       return "R8";
         8'h90, 8'h91, 8'h92:                       return "R9";
         8'h04:                                     return "R10";
         8'h4A:                                     return "R11";
         default:                                   return "R12";
      endcase
   endfunction

   task automatic m_arith(input logic [7:0] b, input bit neg);
      int s;
      s     = neg ? ($signed(m_ax) - $signed(b)) : ($signed(m_ax) + $signed(b));
      m_ovf = (s > 127) || (s < -128);
      m_ax  = s[7:0];
   endtask

   task automatic m_push(input logic [7:0] v);
      m_sp       = m_sp - 8'd1;
      mram[m_sp] = v;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ax = 0; m_bx = 0; m_cx = 0; m_pc = 0; m_sp = 0; m_out = 0;
         m_ovf = 0; m_stb = 0; m_ph = 0; m_tag = "R1";
      end else begin
         m_op  = rom[m_pc];
         m_stb = 0;
         if (m_ph) begin
            m_tag = tag_of(m_pend);
            m_ph  = 0;
            if (m_pend == 8'h04) begin
               m_ax = mram[m_op];
               m_pc = m_pc + 8'd1;
            end else begin
               m_pc = m_ovf ? m_pc + 8'd1 : m_op;
            end
         end else begin
            m_tag = tag_of(m_op);
            m_pc  = m_pc + 8'd1;
            case (m_op)
               8'h00: m_ax = 0;
               8'h31: m_ax = in_data;
               8'h32: begin m_out = m_ax; m_stb = 1; end
               8'h01: m_ax = m_bx;
               8'h02: m_ax = m_cx;
               8'h05: m_bx = m_ax;
               8'h06: m_cx = m_ax;
               8'h04, 8'h4A: begin m_ph = 1; m_pend = m_op; end
               8'h0D: m_arith(m_bx, 0);
               8'h0E: m_arith(m_cx, 0);
               8'h11: m_arith(m_bx, 1);
               8'h12: m_arith(m_cx, 1);
               8'h0C: m_arith(8'd1, 0);
               8'h10: m_arith(8'd1, 1);
               8'h19: m_ax = m_ax | m_bx;
               8'h1E: m_ax = m_ax | m_cx;
               8'h14: m_ax = ~m_ax;
               8'h80: m_push(m_ax);
               8'h81: m_push(m_bx);
               8'h82: m_push(m_cx);
               8'h90: begin m_ax = mram[m_sp]; m_sp = m_sp + 8'd1; end
               8'h91: begin m_bx = mram[m_sp]; m_sp = m_sp + 8'd1; end
               8'h92: begin m_cx = mram[m_sp]; m_sp = m_sp + 8'd1; end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      logic [7:0] op_now, exp_wd;
      bit         exp_we;
      string      pc_tag;
      op_now = rom[m_pc];
      exp_we = !m_ph && rst_n && (op_now == 8'h80 || op_now == 8'h81 || op_now == 8'h82);
      exp_wd = (op_now == 8'h81) ? m_bx : (op_now == 8'h82) ? m_cx : m_ax;
      pc_tag = (m_tag == "R11") ? "R11" : (m_tag == "R1") ? "R1" : "R2";
      chk(pc_tag, "rom_addr", rom_addr, m_pc);
      chk(m_tag, "out_stb", {7'b0, out_stb}, {7'b0, m_stb});
      chk(m_tag, "out_data", out_data, m_out);
      chk("R8", "ram_we", {7'b0, ram_we}, {7'b0, exp_we});
      if (exp_we) begin
         chk("R8", "ram_addr", ram_addr, m_sp - 8'd1);
         chk("R8", "ram_wdata", ram_wdata, exp_wd);
      end
      if (rst_n) begin
         vis[rom_addr] = 1'b1;
         if (out_stb) outs.push_back(out_data);
         if (ram_we)  pushes.push_back({ram_addr, ram_wdata});
      end
   end

   task automatic check_reset_state();
      chk("R1", "reset rom_addr", rom_addr, 8'h00);
      chk("R1", "reset out_data", out_data, 8'h00);
      chk("R1", "reset out_stb", {7'b0, out_stb}, 8'h00);
      chk("R1", "reset ram_we", {7'b0, ram_we}, 8'h00);
   endtask

   initial begin
      logic [7:0] exp_outs [7];
      logic [15:0] exp_push [3];
      for (int i = 0; i < 256; i++) begin
         rom[i] = 8'hFF; ram[i] = 8'h00; mram[i] = 8'h00; vis[i] = 1'b0;
      end
      begin
         logic [7:0] prog [43];
         prog = '{8'h31, 8'h32, 8'h05, 8'h0C, 8'h32, 8'h4A, 8'h08, 8'h06,
                  8'h0D, 8'h32, 8'h4A, 8'h0D, 8'h32, 8'h11, 8'h12, 8'h10,
                  8'h01, 8'h12, 8'h1E, 8'h14, 8'h19, 8'h32, 8'h80, 8'h81,
                  8'h82, 8'h90, 8'h32, 8'h92, 8'h91, 8'h04, 8'hFE, 8'h32,
                  8'h0E, 8'h33, 8'h02, 8'h32, 8'h4A, 8'h30, 8'h00, 8'h0C,
                  8'hFF, 8'h4A, 8'h29};
         for (int i = 0; i < 43; i++) rom[i] = prog[i];
      end
      in_data = 8'h7F;

      repeat (3) @(negedge clk);
      check_reset_state();   // R1
      #1 rst_n = 1'b1;
      repeat (80) @(negedge clk);

      exp_outs = '{8'h7F, 8'h80, 8'hFF, 8'h7F, 8'h80, 8'h7F, 8'h7F};
      chk("R7", "output count", 8'(outs.size()), 8'd7);
      for (int i = 0; i < 7; i++) begin
         if (i < outs.size()) chk(i == 4 ? "R9" : i == 5 ? "R10" : i == 3 ? "R6" : "R4",
                                  "output value", outs[i], exp_outs[i]);
      end
      exp_push = '{16'hFF7F, 16'hFE7F, 16'hFD80};
      chk("R8", "push count", 8'(pushes.size()), 8'd3);
      for (int i = 0; i < 3; i++) begin
         if (i < pushes.size()) begin
            chk("R8", "push addr", pushes[i][15:8], exp_push[i][15:8]);
            chk("R8", "push data", pushes[i][7:0], exp_push[i][7:0]);
         end
      end
      chk("R5", "INC 7F sets flag, jump not taken, 07 fetched", {7'b0, vis[7]}, 8'd1);
      chk("R5", "ADD overflow blocks jump to 30", {7'b0, vis[8'h30]}, 8'd0);
      chk("R11", "taken jump skips 0C", {7'b0, vis[12]}, 8'd0);
      chk("R11", "taken jump lands at 0D", {7'b0, vis[13]}, 8'd1);
      chk("R12", "undefined 33 passes to 22", {7'b0, vis[34]}, 8'd1);
      chk("R11", "final loop", {7'b0, (rom_addr == 8'h29 || rom_addr == 8'h2A)}, 8'd1);

      #1 rst_n = 1'b0;
      @(negedge clk);
      check_reset_state();   // R1 after a second reset
      #1 rst_n = 1'b1;
      repeat (50) @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule